// File: doc/BRIEF.md
# R-type Integer ALU with Immediate Shift Distance

This block is the arithmetic and logic unit for register-to-register integer instructions. It is purely combinational. It takes two source operands, a shift-distance field taken from the instruction word and a function code, and within the same cycle it returns a result word and a flag that says whether that result is all zeros. The function code selects one of six operations: add, subtract, bitwise AND, bitwise OR, logical left shift and logical right shift.

Add and subtract share a single ripple chain of full-adder cells. For subtraction, the second operand is inverted and the chain's carry-in is set to 1. The shift distance never comes from a register. It is the instruction's shift field, and in a shift the first operand plays no part. The value being shifted is the second operand. The surrounding pipeline registers the inputs and outputs, so this block holds no state.

Top module: `rtype_alu`

## Requirements
- R1: Function code 0x20 gives `a_i + b_i` modulo 2^DATA_W. The carry out of the top bit is discarded.
- R2: Function code 0x22 gives `a_i - b_i` modulo 2^DATA_W. A negative difference wraps to its two's-complement form.
- R3: Function code 0x24 gives the bitwise AND of the two operands.
- R4: Function code 0x25 gives the bitwise OR of the two operands.
- R5: Function code 0x00 shifts `b_i` left by `shamt_i` places and fills the vacated low bits with zeros. The value of `a_i` has no effect on the result.
- R6: Function code 0x02 shifts `b_i` right by `shamt_i` places and fills the vacated high bits with zeros. The value of `a_i` has no effect on the result.
- R7: The shift distance is taken only from `shamt_i`. A distance of 0 returns `b_i` unchanged, and a distance of DATA_W-1 keeps a single bit. In the non-shift operations, `shamt_i` has no effect.
- R8: `zero_o` is 1 exactly when every bit of `result_o` is 0.
- R9: Any function code other than 0x00, 0x02, 0x20, 0x22, 0x24 or 0x25 gives a result of 0, and therefore `zero_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | DATA_W | First source operand (not used by shifts) |
| b_i | input | DATA_W | Second source operand; the value shifted by shifts |
| shamt_i | input | $clog2(DATA_W) | Shift distance from the instruction's shift field |
| funct_i | input | 6 | Function code selecting the operation |
| result_o | output | DATA_W | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench builds the block with its default width of 32 bits. At that width the shift field is 5 bits wide, so every legal shift distance from 0 to 31 is reachable. Sign-boundary operands such as 0x7FFFFFFF and 0x80000000 can be applied, and so can the all-ones operand that pushes a carry through the whole adder chain. The 32-bit width also lets the bench sweep every distance in both shift directions. It can show that the first operand leaves a shift untouched, and it can drive unlisted function codes next to legal ones (0x21 beside add, 0x03 beside srl).

// File: rtl/rtype_alu_pkg.sv
package rtype_alu_pkg;

  localparam int FUNCT_W = 6;

  typedef enum logic [FUNCT_W-1:0] {
    FN_SLL = 6'h00,
    FN_SRL = 6'h02,
    FN_ADD = 6'h20,
    FN_SUB = 6'h22,
    FN_AND = 6'h24,
    FN_OR  = 6'h25
  } alu_fn_e;

endpackage

// File: rtl/rtype_alu_addsub.sv
// Ripple-carry adder/subtractor built from full-adder cells.
module rtype_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o
);

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] carry;

  // Subtraction: invert the second operand and inject a carry of 1.
  assign b_eff    = op_b_i ^ {DATA_W{sub_i}};
  assign carry[0] = sub_i;

  for (genvar g = 0; g < DATA_W; g++) begin : g_cell
    assign sum_o[g] = op_a_i[g] ^ b_eff[g] ^ carry[g];
    if (g < DATA_W - 1) begin : g_carry
      assign carry[g+1] = (op_a_i[g] & b_eff[g]) |
                          (op_a_i[g] & carry[g]) |
                          (b_eff[g]  & carry[g]);
    end
  end

endmodule

// File: rtl/rtype_alu_shift.sv
// Logarithmic barrel shifter; SHIFT_LEFT picks the direction, zero fill.
module rtype_alu_shift #(
  parameter int DATA_W     = 32,
  parameter bit SHIFT_LEFT = 1'b1,
  localparam int SHAMT_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] dist_i,
  output logic [DATA_W-1:0]  data_o
);

  logic [DATA_W-1:0] stage [SHAMT_W+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [DATA_W-1:0] moved;
    if (SHIFT_LEFT) begin : g_left
      assign moved = {stage[k][DATA_W-1-STEP:0], {STEP{1'b0}}};
    end else begin : g_right
      assign moved = {{STEP{1'b0}}, stage[k][DATA_W-1:STEP]};
    end
    assign stage[k+1] = dist_i[k] ? moved : stage[k];
  end

  assign data_o = stage[SHAMT_W];

endmodule

// File: rtl/rtype_alu.sv
// Combinational R-type ALU: add, sub, and, or, sll, srl.
module rtype_alu
  import rtype_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               zero_o
);

  logic              is_sub;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] sll_res;
  logic [DATA_W-1:0] srl_res;
  logic [DATA_W-1:0] result_d;

  assign is_sub = (funct_i == FN_SUB);

  rtype_alu_addsub #(
    .DATA_W (DATA_W)
  ) u_addsub (
    .op_a_i (a_i),
    .op_b_i (b_i),
    .sub_i  (is_sub),
    .sum_o  (arith_res)
  );

  rtype_alu_shift #(
    .DATA_W     (DATA_W),
    .SHIFT_LEFT (1'b1)
  ) u_sll (
    .data_i (b_i),
    .dist_i (shamt_i),
    .data_o (sll_res)
  );

  rtype_alu_shift #(
    .DATA_W     (DATA_W),
    .SHIFT_LEFT (1'b0)
  ) u_srl (
    .data_i (b_i),
    .dist_i (shamt_i),
    .data_o (srl_res)
  );

  // Result select; unlisted function codes yield zero.
  always_comb begin
    result_d = '0;
    case (funct_i)
      FN_ADD,
      FN_SUB:  result_d = arith_res;
      FN_AND:  result_d = a_i & b_i;
      FN_OR:   result_d = a_i | b_i;
      FN_SLL:  result_d = sll_res;
      FN_SRL:  result_d = srl_res;
      default: result_d = '0;
    endcase
  end

  assign result_o = result_d;
  assign zero_o   = ~|result_d;

endmodule

// File: rtl/rtype_alu_chk.sv
// Checker for rtype_alu, compares the ports against behavioural operators.
module rtype_alu_chk
  import rtype_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [FUNCT_W-1:0] funct_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               zero_o
);

  logic known;
  assign known = !$isunknown({a_i, b_i, shamt_i, funct_i});

  always_comb begin
    if (known) begin
      if (funct_i == FN_ADD)
        a_r1_add: assert (result_o == DATA_W'(a_i + b_i))
          else $error("R1 add mismatch");
      if (funct_i == FN_SUB)
        a_r2_sub: assert (result_o == DATA_W'(a_i - b_i))
          else $error("R2 sub mismatch");
      if (funct_i == FN_AND)
        a_r3_and: assert (result_o == (a_i & b_i))
          else $error("R3 and mismatch");
      if (funct_i == FN_OR)
        a_r4_or: assert (result_o == (a_i | b_i))
          else $error("R4 or mismatch");
      if (funct_i == FN_SLL)
        a_r5_sll: assert (result_o == (b_i << shamt_i))
          else $error("R5 sll mismatch");
      if (funct_i == FN_SRL)
        a_r6_srl: assert (result_o == (b_i >> shamt_i))
          else $error("R6 srl mismatch");
      if ((funct_i == FN_SLL || funct_i == FN_SRL) && shamt_i == '0)
        a_r7_shift_zero_dist: assert (result_o == b_i)
          else $error("R7 zero-distance shift altered operand");
      a_r8_zero_flag: assert (zero_o == (result_o == '0))
        else $error("R8 zero flag mismatch");
      if (!(funct_i inside {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLL, FN_SRL}))
        a_r9_unknown_fn: assert (result_o == '0 && zero_o)
          else $error("R9 unlisted function code not zero");
    end
  end

endmodule

bind rtype_alu rtype_alu_chk #(
  .DATA_W (DATA_W)
) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .shamt_i  (shamt_i),
  .funct_i  (funct_i),
  .result_o (result_o),
  .zero_o   (zero_o)
);

// File: tb/rtype_alu_tb_top.sv
module rtype_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int WATCHDOG   = 200000;

  logic              clk;
  logic              rst_n;
  logic [31:0]       a;
  logic [31:0]       b;
  logic [4:0]        shamt;
  logic [5:0]        funct;
  logic [31:0]       result;
  logic              zero;

  int checks;
  int errors;
  bit done;

  rtype_alu #(
    .DATA_W (DATA_W)
  ) dut_i (
    .a_i      (a),
    .b_i      (b),
    .shamt_i  (shamt),
    .funct_i  (funct),
    .result_o (result),
    .zero_o   (zero)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Drive after a rising edge, sample at the following falling edge.
  task automatic run(input string req, input logic [31:0] ta, input logic [31:0] tb,
                     input logic [4:0] ts, input logic [5:0] tf,
                     input logic [31:0] exp_res);
    logic exp_zero;
    @(posedge clk);
    a = ta; b = tb; shamt = ts; funct = tf;
    @(negedge clk);
    exp_zero = (exp_res == 32'h0);
    checks++;
    if (result !== exp_res || zero !== exp_zero) begin
      errors++;
      $display("FAIL %s: funct=%h a=%h b=%h sh=%0d result=%h zero=%b expected result=%h zero=%b",
               req, tf, ta, tb, ts, result, zero, exp_res, exp_zero);
    end
  endtask

  task automatic t_reset_state();
    run("R1 R8 idle", 32'h0, 32'h0, 5'd0, 6'h20, 32'h0);
  endtask

  task automatic t_add();
    run("R1", 32'd5, 32'd7, 5'd0, 6'h20, 32'd12);
    run("R1 R8 wrap", 32'hFFFF_FFFF, 32'h1, 5'd0, 6'h20, 32'h0);
    run("R1 sign edge", 32'h7FFF_FFFF, 32'h1, 5'd0, 6'h20, 32'h8000_0000);
    run("R7 add ignores shamt", 32'd100, 32'd23, 5'd31, 6'h20, 32'd123);
  endtask

  task automatic t_sub();
    run("R2", 32'd10, 32'd3, 5'd0, 6'h22, 32'd7);
    run("R2 negative", 32'd3, 32'd10, 5'd0, 6'h22, 32'hFFFF_FFF9);
    run("R2 R8 equal", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0, 6'h22, 32'h0);
    run("R2 borrow through", 32'h0, 32'h1, 5'd17, 6'h22, 32'hFFFF_FFFF);
  endtask

  task automatic t_logic();
    run("R3", 32'hF0F0_F0F0, 32'hFF00_FF00, 5'd0, 6'h24, 32'hF000_F000);
    run("R3 R8 disjoint", 32'hAAAA_AAAA, 32'h5555_5555, 5'd0, 6'h24, 32'h0);
    run("R4", 32'hF0F0_F0F0, 32'h0F0F_0F0F, 5'd0, 6'h25, 32'hFFFF_FFFF);
    run("R4 R8 both zero", 32'h0, 32'h0, 5'd3, 6'h25, 32'h0);
  endtask

  task automatic t_sll();
    run("R5", 32'h0, 32'h1234_5678, 5'd4, 6'h00, 32'h2345_6780);
    run("R5 a ignored", 32'hFFFF_FFFF, 32'h1234_5678, 5'd4, 6'h00, 32'h2345_6780);
    run("R7 sll max", 32'h0, 32'h1, 5'd31, 6'h00, 32'h8000_0000);
    run("R7 sll zero dist", 32'h5, 32'hCAFE_F00D, 5'd0, 6'h00, 32'hCAFE_F00D);
    for (int s = 0; s < 32; s++)
      run("R5 sweep", 32'h1357_9BDF, 32'hA5A5_A5A5, 5'(s), 6'h00, 32'hA5A5_A5A5 << s);
  endtask

  task automatic t_srl();
    run("R6 zero fill", 32'h0, 32'hF000_0000, 5'd4, 6'h02, 32'h0F00_0000);
    run("R6", 32'hFFFF_FFFF, 32'h1234_5678, 5'd8, 6'h02, 32'h0012_3456);
    run("R7 srl max", 32'h0, 32'h8000_0000, 5'd31, 6'h02, 32'h1);
    run("R6 R8 shifted out", 32'h1, 32'h7FFF_FFFF, 5'd31, 6'h02, 32'h0);
    for (int s = 0; s < 32; s++)
      run("R6 sweep", 32'hFFFF_FFFF, 32'h8C3A_5F11, 5'(s), 6'h02, 32'h8C3A_5F11 >> s);
  endtask

  task automatic t_unlisted();
    run("R9 0x21", 32'd5, 32'd7, 5'd0, 6'h21, 32'h0);
    run("R9 0x03", 32'h0, 32'hFFFF_FFFF, 5'd1, 6'h03, 32'h0);
    run("R9 0x3F", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 6'h3F, 32'h0);
    run("R9 0x26", 32'hFFFF_FFFF, 32'h0, 5'd0, 6'h26, 32'h0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    a = '0; b = '0; shamt = '0; funct = 6'h20;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add();
    t_sub();
    t_logic();
    t_sll();
    t_srl();
    t_unlisted();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion within %0d cycles",
               WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule